// File: doc/BRIEF.md
# NAND Page Transfer Position Tracker

This block follows the progress of a NAND flash page transfer inside a flash controller. It keeps a byte position that points at the next byte to be moved. The position covers the data area of the page and the spare area behind it. Only the host accesses that actually move page bytes advance the position. These are a read through the FIFO data port, and a write through either the FIFO data port or the direct data port. Reads of the direct data port or of the address/command port leave the position where it is.

Software starts and stops the transfer through a control register. A stop command returns the block to idle and clears the run flag. If the spare area is being processed when the stop arrives, the stop is held back until the last spare byte has been counted, so the spare zone is always completed. A data-flow end-of-page pulse latches how many whole ECC sectors lie between the offset where the transfer started and the end of the data area. Software uses that count when a flow did not start at the beginning of a page. A two-byte logical block address descriptor, meant for the spare zone, is written one byte at a time. A data-flow stop pulse sets an interrupt flag that software clears.

The page geometry is given by parameters: data bytes, spare bytes, and sector bytes, which must be a power of two. Register reads return data one cycle after the read strobe.

Top module: `nand_pos_tracker`

## Requirements
- R1: After reset the position is 0, the run flag is 0, the ECC-ready count is 0, the interrupt flag is 0 and both descriptor bytes are 0x00.
- R2: The position increments by one on a read of the FIFO data port (address 1), on a write of the FIFO data port (address 1) and on a write of the direct data port (address 0).
- R3: A read of the direct data port (address 0), and any access to the address/command port (address 2) or to any other register, leaves the position unchanged.
- R4: With 512 data bytes and 16 spare bytes, moving a whole page plus its spare zone from position 0 leaves the position at 528.
- R5: The position never exceeds data bytes plus spare bytes, and further counting accesses hold it there. A start command issued while it sits at that limit sets it to 0.
- R6: Writes to the position high byte (address 4) and low byte (address 5) load the position only while the debug_mode input is 1 and the run flag is 0; otherwise they are ignored. A loaded value above the limit is clamped to the limit.
- R7: A write of the control register (address 3) with bit 0 set starts the transfer (run flag 1), and with bit 1 set stops it. A stop takes priority over a start in the same write. A stop given while spare-area processing is not in progress clears the run flag at the write's clock edge.
- R8: A stop given while the run flag is 1 and the position lies in the spare area (at or above data bytes, below the limit) keeps the run flag at 1 and marks a pending stop (control read bit 1). The run flag clears one cycle after the position reaches the limit.
- R9: On a flow_eop pulse the ECC-ready count (address 6) becomes the number of whole sectors from the position captured at the last start to the end of the data area, or 0 if that position is at or beyond the data area. For 2048 data bytes, 512-byte sectors and a start at 512, the count is 3.
- R10: Writes to the descriptor port (address 7) fill byte 0 (the high byte, read at address 8) and then byte 1 (read at address 9), alternating. The bytes are stored exactly as written, with no header or parity generated in hardware.
- R11: A flow_done pulse sets the interrupt flag (control read bit 2). It stays set until a control write with bit 2 set clears it, and a set in the same cycle wins.
- R12: A read strobe loads reg_rdata at the next clock edge. Address 3 reads {irq, pending stop, run} in bits 2..0. Addresses 4 and 5 read the position bytes. Reads of the data ports return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| debug_mode | input | 1 | Enables position loads while idle |
| flow_eop | input | 1 | Data flow reached the end of the page |
| flow_done | input | 1 | Data flow stopped |
| run_o | output | 1 | Run flag |
| pos_o | output | 16 | Byte position of the next byte |
| ecc_cnt_o | output | ECC_W | ECC-ready count |
| lba_o | output | 16 | Descriptor, byte 0 in bits 15:8 |
| irq_o | output | 1 | End-of-transfer interrupt flag |

## Verification
A wrong position shows on pos_o at the clock edge right after the access that caused it, and it stays wrong for every later byte of the page, so the first faulty access can be located exactly. A lost or early stop shows on run_o one cycle after the stop write or after the spare limit is reached. A wrong captured start offset stays hidden until the next flow_eop, where it shows as a wrong ECC-ready count. A descriptor pointer that is out of step shows only at the second write, as bytes swapped on lba_o.

// File: rtl/nand_pos_pkg.sv
package nand_pos_pkg;

    // position field is exposed as two register bytes
    localparam int POS_W = 16;

    typedef enum logic [3:0] {
        RA_DDATA = 4'd0,
        RA_FDATA = 4'd1,
        RA_ADC   = 4'd2,
        RA_CTRL  = 4'd3,
        RA_POSH  = 4'd4,
        RA_POSL  = 4'd5,
        RA_ECC   = 4'd6,
        RA_LBAW  = 4'd7,
        RA_LBAH  = 4'd8,
        RA_LBAL  = 4'd9
    } reg_addr_e;

    // control write bits
    localparam int CB_START  = 0;
    localparam int CB_STOP   = 1;
    localparam int CB_IRQCLR = 2;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
        logic       ptr;
    } lba_st_t;

endpackage

// File: rtl/nand_pos_cnt.sv
module nand_pos_cnt
    import nand_pos_pkg::*;
#(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             start_i,
    input  logic             ld_ok_i,
    input  logic             ld_hi_i,
    input  logic             ld_lo_i,
    input  logic [7:0]       ld_data_i,
    output logic [POS_W-1:0] pos_o
);
    localparam int TOTAL = DATA_BYTES + SPARE_BYTES;
    localparam logic [POS_W-1:0] TOTAL_P = POS_W'(TOTAL);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } st_t;

    st_t              q, d;
    logic [POS_W-1:0] ld_val;

    always_comb begin
        d      = q;
        ld_val = q.pos;
        if (ld_hi_i) ld_val[15:8] = ld_data_i;
        if (ld_lo_i) ld_val[7:0]  = ld_data_i;
        if (start_i && q.pos == TOTAL_P) begin
            d.pos = '0;
        end else if (ld_ok_i && (ld_hi_i || ld_lo_i)) begin
            d.pos = (ld_val > TOTAL_P) ? TOTAL_P : ld_val;
        end else if (adv_i && q.pos < TOTAL_P) begin
            d.pos = q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pos_o = q.pos;
endmodule

// File: rtl/nand_run_ctl.sv
module nand_run_ctl
    import nand_pos_pkg::*;
#(
    parameter int DATA_BYTES   = 2048,
    parameter int SPARE_BYTES  = 64,
    parameter int SECTOR_BYTES = 512,
    parameter int ECC_W        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             irq_clr_i,
    input  logic             flow_eop_i,
    input  logic             flow_done_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             run_o,
    output logic             pend_o,
    output logic             irq_o,
    output logic [ECC_W-1:0] ecc_o
);
    localparam int SEC_SH = $clog2(SECTOR_BYTES);
    localparam logic [POS_W-1:0] DATA_P  = POS_W'(DATA_BYTES);
    localparam logic [POS_W-1:0] TOTAL_P = POS_W'(DATA_BYTES + SPARE_BYTES);

    typedef struct packed {
        logic             run;
        logic             pend;
        logic             irq;
        logic [POS_W-1:0] off;
        logic [ECC_W-1:0] ecc;
    } st_t;

    st_t  q, d;
    logic spare_act;

    assign spare_act = q.run && (pos_i >= DATA_P) && (pos_i < TOTAL_P);

    always_comb begin
        d = q;
        if (stop_i) begin
            if (spare_act) begin
                d.pend = 1'b1;
            end else begin
                d.run  = 1'b0;
                d.pend = 1'b0;
            end
        end else if (start_i) begin
            d.run  = 1'b1;
            d.pend = 1'b0;
            d.off  = (pos_i == TOTAL_P) ? '0 : pos_i;
        end else if (q.pend && !spare_act) begin
            d.run  = 1'b0;
            d.pend = 1'b0;
        end

        if (flow_done_i)    d.irq = 1'b1;
        else if (irq_clr_i) d.irq = 1'b0;

        if (flow_eop_i) begin
            if (q.off >= DATA_P) d.ecc = '0;
            else                 d.ecc = ECC_W'((DATA_P - q.off) >> SEC_SH);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run_o  = q.run;
    assign pend_o = q.pend;
    assign irq_o  = q.irq;
    assign ecc_o  = q.ecc;
endmodule

// File: rtl/nand_lba_desc.sv
module nand_lba_desc
    import nand_pos_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [7:0]  data_i,
    output logic [15:0] lba_o
);
    lba_st_t q, d;

    always_comb begin
        d = q;
        if (wr_i) begin
            if (!q.ptr) d.hi = data_i;
            else        d.lo = data_i;
            d.ptr = ~q.ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lba_o = {q.hi, q.lo};
endmodule

// File: rtl/nand_pos_tracker.sv
module nand_pos_tracker
    import nand_pos_pkg::*;
#(
    parameter int DATA_BYTES   = 2048,
    parameter int SPARE_BYTES  = 64,
    parameter int SECTOR_BYTES = 512,
    localparam int ECC_W       = $clog2(DATA_BYTES / SECTOR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [3:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             debug_mode,
    input  logic             flow_eop,
    input  logic             flow_done,
    output logic             run_o,
    output logic [POS_W-1:0] pos_o,
    output logic [ECC_W-1:0] ecc_cnt_o,
    output logic [15:0]      lba_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [7:0] rdata;
    } rd_st_t;

    rd_st_t rd_q, rd_d;
    logic   adv, ctrl_wr, start, stop, irq_clr, pend;

    assign adv = (reg_wr && (reg_addr == RA_DDATA || reg_addr == RA_FDATA))
              || (reg_rd && reg_addr == RA_FDATA);
    assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
    assign start   = ctrl_wr && reg_wdata[CB_START];
    assign stop    = ctrl_wr && reg_wdata[CB_STOP];
    assign irq_clr = ctrl_wr && reg_wdata[CB_IRQCLR];

    nand_pos_cnt #(
        .DATA_BYTES (DATA_BYTES),
        .SPARE_BYTES(SPARE_BYTES)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (adv),
        .start_i  (start && !stop),
        .ld_ok_i  (debug_mode && !run_o),
        .ld_hi_i  (reg_wr && reg_addr == RA_POSH),
        .ld_lo_i  (reg_wr && reg_addr == RA_POSL),
        .ld_data_i(reg_wdata),
        .pos_o    (pos_o)
    );

    nand_run_ctl #(
        .DATA_BYTES  (DATA_BYTES),
        .SPARE_BYTES (SPARE_BYTES),
        .SECTOR_BYTES(SECTOR_BYTES),
        .ECC_W       (ECC_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .stop_i     (stop),
        .irq_clr_i  (irq_clr),
        .flow_eop_i (flow_eop),
        .flow_done_i(flow_done),
        .pos_i      (pos_o),
        .run_o      (run_o),
        .pend_o     (pend),
        .irq_o      (irq_o),
        .ecc_o      (ecc_cnt_o)
    );

    nand_lba_desc u_lba (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (reg_wr && reg_addr == RA_LBAW),
        .data_i(reg_wdata),
        .lba_o (lba_o)
    );

    always_comb begin
        rd_d = rd_q;
        if (reg_rd) begin
            case (reg_addr)
                RA_CTRL: rd_d.rdata = {5'b0, irq_o, pend, run_o};
                RA_POSH: rd_d.rdata = pos_o[15:8];
                RA_POSL: rd_d.rdata = pos_o[7:0];
                RA_ECC:  rd_d.rdata = 8'(ecc_cnt_o);
                RA_LBAH: rd_d.rdata = lba_o[15:8];
                RA_LBAL: rd_d.rdata = lba_o[7:0];
                default: rd_d.rdata = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata = rd_q.rdata;
endmodule

// File: rtl/nand_pos_tracker_chk.sv
module nand_pos_tracker_chk
    import nand_pos_pkg::*;
#(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [3:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic             flow_done,
    input logic             run_o,
    input logic [POS_W-1:0] pos_o,
    input logic             irq_o
);
    localparam logic [POS_W-1:0] DATA_P  = POS_W'(DATA_BYTES);
    localparam logic [POS_W-1:0] TOTAL_P = POS_W'(DATA_BYTES + SPARE_BYTES);

    logic in_spare, stop_wr;
    assign in_spare = run_o && pos_o >= DATA_P && pos_o < TOTAL_P;
    assign stop_wr  = reg_wr && reg_addr == RA_CTRL && reg_wdata[CB_STOP];

    // R5
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_o <= TOTAL_P);

    // R2
    fifo_rd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == RA_FDATA && pos_o < TOTAL_P)
        |=> pos_o == $past(pos_o) + 16'd1);

    // R3
    direct_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && (reg_addr == RA_DDATA || reg_addr == RA_ADC))
        |=> $stable(pos_o));

    // R6
    load_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == RA_POSH || reg_addr == RA_POSL) && run_o)
        |=> $stable(pos_o));

    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && !in_spare) |=> !run_o);

    // R8
    stop_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && in_spare) |=> run_o);

    // R11
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flow_done |=> irq_o);
endmodule

bind nand_pos_tracker nand_pos_tracker_chk #(
    .DATA_BYTES (DATA_BYTES),
    .SPARE_BYTES(SPARE_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .flow_done(flow_done),
    .run_o    (run_o),
    .pos_o    (pos_o),
    .irq_o    (irq_o)
);

// File: tb/nand_pos_tracker_test.sv
`timescale 1ns/1ps
module nand_pos_tracker_test;
    localparam int DATA  = 2048;
    localparam int SPARE = 64;
    localparam int TOTAL = DATA + SPARE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        debug_mode = 1'b0, flow_eop = 1'b0, flow_done = 1'b0;
    logic [7:0]  rdata, rdata_s;
    logic        run, run_s, irq, irq_s;
    logic [15:0] pos, pos_s, lba, lba_s;
    logic [2:0]  ecc;
    logic        ecc_s;
    int          checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    nand_pos_tracker uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata),
        .debug_mode(debug_mode), .flow_eop(flow_eop), .flow_done(flow_done),
        .run_o(run), .pos_o(pos), .ecc_cnt_o(ecc), .lba_o(lba), .irq_o(irq)
    );

    nand_pos_tracker #(.DATA_BYTES(512), .SPARE_BYTES(16), .SECTOR_BYTES(512)) uut_small (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_s),
        .debug_mode(debug_mode), .flow_eop(flow_eop), .flow_done(flow_done),
        .run_o(run_s), .pos_o(pos_s), .ecc_cnt_o(ecc_s), .lba_o(lba_s), .irq_o(irq_s)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = rdata;
    endtask

    task automatic pulse_eop();
        @(negedge clk); flow_eop = 1'b1;
        @(negedge clk); flow_eop = 1'b0;
    endtask

    task automatic load_pos(input int v);
        debug_mode = 1'b1;
        bus_wr(4'd4, 8'(v >> 8));
        bus_wr(4'd5, 8'(v));
        debug_mode = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        check("R1 pos", pos, 0);
        check("R1 run", run, 0);
        check("R1 ecc", ecc, 0);
        check("R1 irq", irq, 0);
        check("R1 lba", lba, 0);
        bus_rd(4'd3, v);
        check("R12 ctrl read after reset", v, 0);
    endtask

    task automatic t_advance();
        logic [7:0] v;
        do_reset();
        repeat (3) bus_wr(4'd1, 8'h5A);
        check("R2 fifo writes", pos, 3);
        bus_rd(4'd1, v);
        bus_rd(4'd1, v);
        check("R2 fifo reads", pos, 5);
        check("R12 fifo read data", v, 0);
        bus_wr(4'd0, 8'h11);
        check("R2 direct write", pos, 6);
    endtask

    task automatic t_no_advance();
        logic [7:0] v;
        bus_rd(4'd0, v);
        bus_rd(4'd2, v);
        bus_wr(4'd2, 8'h70);
        bus_rd(4'd6, v);
        check("R3 direct/adc access", pos, 6);
        bus_rd(4'd5, v);
        check("R12 pos low read", v, 6);
    endtask

    task automatic t_debug_load();
        logic [7:0] v;
        bus_wr(4'd4, 8'h03);
        check("R6 load without debug", pos, 6);
        bus_wr(4'd3, 8'h01);
        debug_mode = 1'b1;
        bus_wr(4'd4, 8'h01);
        check("R6 load while running", pos, 6);
        bus_wr(4'd3, 8'h02);
        check("R7 stop outside spare", run, 0);
        bus_wr(4'd4, 8'h02);
        bus_wr(4'd5, 8'h10);
        check("R6 load idle debug", pos, 16'h0210);
        bus_rd(4'd4, v);
        check("R12 pos high read", v, 8'h02);
        bus_wr(4'd4, 8'hFF);
        check("R6 clamp", pos, TOTAL);
        debug_mode = 1'b0;
    endtask

    task automatic ecc_case(input int off, input int exp, input string tag);
        load_pos(off);
        bus_wr(4'd3, 8'h01);
        pulse_eop();
        check(tag, ecc, exp);
        bus_wr(4'd3, 8'h02);
    endtask

    task automatic t_ecc();
        logic [7:0] v;
        do_reset();
        ecc_case(512,  3, "R9 start 512");
        bus_rd(4'd6, v);
        check("R9 ecc register read", v, 3);
        ecc_case(1024, 2, "R9 start 1024");
        ecc_case(1600, 0, "R9 partial sector");
        ecc_case(0,    4, "R9 full page");
    endtask

    task automatic t_spare_stop();
        logic [7:0] v;
        do_reset();
        load_pos(DATA + 10);
        bus_wr(4'd3, 8'h01);
        bus_wr(4'd3, 8'h02);
        bus_rd(4'd3, v);
        check("R8 pending stop in spare", v, 8'h03);
        repeat (TOTAL - DATA - 11) bus_wr(4'd1, 8'h00);
        check("R8 still running", run, 1);
        check("R8 pos before last", pos, TOTAL - 1);
        bus_wr(4'd1, 8'h00);
        check("R8 pos at limit", pos, TOTAL);
        @(negedge clk);
        check("R8 run cleared after spare", run, 0);
        repeat (3) bus_wr(4'd1, 8'h00);
        check("R5 saturation", pos, TOTAL);
        bus_wr(4'd3, 8'h01);
        check("R5 wrap on start", pos, 0);
        check("R7 start sets run", run, 1);
        bus_wr(4'd3, 8'h03);
        check("R7 stop wins over start", run, 0);
    endtask

    task automatic t_small_page();
        do_reset();
        bus_wr(4'd3, 8'h01);
        repeat (512) bus_wr(4'd1, 8'hAA);
        repeat (16)  bus_wr(4'd0, 8'h55);
        check("R4 full page plus spare", pos_s, 528);
    endtask

    task automatic t_lba();
        logic [7:0] v;
        do_reset();
        bus_wr(4'd7, 8'h10);
        check("R10 byte0 first", lba, 16'h1000);
        bus_wr(4'd7, 8'hA5);
        check("R10 both bytes", lba, 16'h10A5);
        bus_rd(4'd8, v);
        check("R10 high read", v, 8'h10);
        bus_rd(4'd9, v);
        check("R10 low read", v, 8'hA5);
        bus_wr(4'd7, 8'hFF);
        bus_wr(4'd7, 8'hFF);
        check("R10 stored as written", lba, 16'hFFFF);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        @(negedge clk); flow_done = 1'b1;
        @(negedge clk); flow_done = 1'b0;
        check("R11 irq set", irq, 1);
        repeat (4) @(negedge clk);
        bus_rd(4'd3, v);
        check("R11 irq held", v, 8'h04);
        bus_wr(4'd3, 8'h04);
        check("R11 irq cleared", irq, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_advance();
        t_no_advance();
        t_debug_load();
        t_ecc();
        t_spare_stop();
        t_small_page();
        t_lba();
        t_irq();
        finish_run();
    end
endmodule